// File: doc/BRIEF.md
# Two-Key Service Watchdog

This block is a computer-operating-properly watchdog. While enabled, a free-running counter advances once per clock. If software does not service it in time, the counter reaches its terminal count and the block raises a system reset request for a fixed number of cycles.

Servicing takes two writes to a byte-wide service register, in order. The first write carries an arming key. A later write carries a clearing key, and only that second write restarts the count. Any other bus writes may fall between the two keys. A 2-bit select input chooses one of four timeout lengths.

The write port is a plain strobe interface with no back-pressure: the block samples address and data on every clock edge where the strobe is high. It has no read path.

Top module: `wdg_two_key_top`

## Requirements
- R1: After reset the block is in its idle state: `rst_req` is low, the count is zero and the key sequence is disarmed.
- R2: With `enable` high, `rst_req` rises on clock edge number T, counted from the first enabled edge after reset or after the last count restart. T is 2^(BASE_EXP + 2*`tmo_sel`), where `tmo_sel` 0..3 gives 16, 64, 256 and 1024 at the default BASE_EXP of 4.
- R3: `rst_req` stays high for exactly 4 clock cycles. During those cycles service writes are ignored. After the pulse the count restarts from zero and the sequence is disarmed.
- R4: A write of 0x55 to address 0x103A arms the sequence and does not restart the count.
- R5: A write of 0xAA to address 0x103A while armed restarts the count from zero, so the next request comes T edges later. It also disarms the sequence, so a second 0xAA has no effect.
- R6: A write of 0xAA to address 0x103A while disarmed is ignored: it neither restarts the count nor arms.
- R7: Two kinds of write leave the armed state unchanged: a write of any other value to 0x103A, and a write of any value to any other address.
- R8: While `enable` is low the count is held at zero and `rst_req` never rises. Counting resumes from zero when `enable` returns high.
- R9: If a clearing write lands on the same edge as the terminal count, the clear wins and no reset is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Watchdog enable |
| tmo_sel | input | 2 | Timeout length select |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Byte write address |
| wr_data | input | 8 | Write data |
| rst_req | output | 1 | System reset request |

## Verification
A wrong armed flag shows at the ports as a reset request at the wrong time. If a clear is missed, the request arrives T edges after the original start. If a clear is spurious, the request arrives T edges after a write that should have been ignored. Every internal fault therefore surfaces within one timeout period, as an edge-exact shift in when `rst_req` rises. The bench measures that rise time against the edge index expected from the write schedule.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [7:0] KEY_ARM   = 8'h55;
  localparam logic [7:0] KEY_CLEAR = 8'hAA;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/wdg_key_gate.sv
module wdg_key_gate
  import wdg_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] SVC_ADDR = 16'h103A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  byte_t             wr_data_i,
  output logic              clear_o
);
  logic armed_q;
  logic hit;
  logic is_arm, is_clr;

  assign hit    = wr_en_i && (wr_addr_i == SVC_ADDR[ADDR_W-1:0]) && !hold_i;
  assign is_arm = hit && (wr_data_i == KEY_ARM);
  assign is_clr = hit && (wr_data_i == KEY_CLEAR);
  assign clear_o = is_clr && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                armed_q <= 1'b0;
    else if (hold_i)           armed_q <= 1'b0;
    else if (is_arm)           armed_q <= 1'b1;
    else if (is_clr && armed_q) armed_q <= 1'b0;
  end

  AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    is_arm |=> armed_q); // R4
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (is_clr && !armed_q) |=> !armed_q); // R6
endmodule

// File: rtl/wdg_expiry_counter.sv
module wdg_expiry_counter #(
  parameter int BASE_EXP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       hold_i,
  input  logic       clear_i,
  input  logic [1:0] sel_i,
  output logic       fire_o
);
  localparam int CW = BASE_EXP + 7;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] term;
  logic          run;

  always_comb begin
    term = (CW'(1) << (BASE_EXP + 2 * int'(sel_i))) - CW'(1);
  end

  assign run    = enable_i && !hold_i && !clear_i;
  assign fire_o = run && (cnt_q >= term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (fire_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/wdg_reset_stretch.sv
module wdg_reset_stretch #(
  parameter int PULSE_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic rst_req_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              left_q <= '0;
    else if (fire_i)         left_q <= PW'(PULSE_LEN);
    else if (left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign rst_req_o = (left_q != '0);

  AST_PULSE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_req_o) |-> $past(rst_req_o, 4)); // R3
  AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req_o) |-> $past(fire_i)); // R2
endmodule

// File: rtl/wdg_two_key_top.sv
module wdg_two_key_top #(
  parameter int          BASE_EXP  = 4,
  parameter int          PULSE_LEN = 4,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] SVC_ADDR  = 16'h103A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        tmo_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              rst_req
);
  logic clear, fire;

  wdg_key_gate #(.ADDR_W(ADDR_W), .SVC_ADDR(SVC_ADDR)) u_key (
    .clk(clk), .rst_n(rst_n), .hold_i(rst_req),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .clear_o(clear)
  );

  wdg_expiry_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .hold_i(rst_req),
    .clear_i(clear), .sel_i(tmo_sel), .fire_o(fire)
  );

  wdg_reset_stretch #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .rst_req_o(rst_req)
  );

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !rst_req) |=> !rst_req); // R8
  AST_CLEAR_BLOCKS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !rst_req) |=> !rst_req); // R9
endmodule

// File: tb/tb_wdg_two_key_top.sv
module tb_wdg_two_key_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  tmo_sel = 2'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = 16'h0;
  logic [7:0]  wr_data = 8'h0;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [15:0] SVC = 16'h103A;

  wdg_two_key_top dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tmo_sel(tmo_sel),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rst_req(rst_req)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic restart(input bit en, input logic [1:0] sel);
    rst_n = 1'b0;
    enable = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    tmo_sel = sel;
    enable = en;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic edges_to_req(input int max, output int n);
    n = -1;
    for (int i = 1; i <= max; i++) begin
      tick();
      if (rst_req) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic wait_drop();
    for (int i = 0; i < 20 && rst_req; i++) tick();
  endtask

  task automatic t_reset_state();
    restart(1'b0, 2'd0);
    check("R1 rst_req low after reset", rst_req, 0);
  endtask

  task automatic t_timeouts();
    int n;
    for (int s = 0; s < 4; s++) begin
      restart(1'b1, 2'(s));
      edges_to_req(1100, n);
      check($sformatf("R2 timeout sel=%0d", s), n, 1 << (4 + 2 * s));
    end
  endtask

  task automatic t_pulse();
    int w, n;
    restart(1'b1, 2'd0);
    edges_to_req(40, n);
    w = 1;
    for (int i = 0; i < 10; i++) begin
      tick();
      if (!rst_req) break;
      w++;
    end
    check("R3 pulse width", w, 4);
    edges_to_req(40, n);
    check("R3 restart after pulse", n, 16);
  endtask

  task automatic t_disarm_after_pulse();
    int n;
    restart(1'b1, 2'd0);
    wr(SVC, 8'h55);
    edges_to_req(40, n);
    wait_drop();
    wr(SVC, 8'hAA);
    edges_to_req(40, n);
    check("R3 armed cleared by pulse", n, 15);
  endtask

  task automatic t_arm_only();
    int n;
    restart(1'b1, 2'd0);
    wr(SVC, 8'h55);
    edges_to_req(40, n);
    check("R4 arm does not restart", n, 15);
  endtask

  task automatic t_service();
    int n;
    restart(1'b1, 2'd0);
    for (int i = 0; i < 3; i++) tick();
    wr(SVC, 8'h55);
    tick();
    tick();
    wr(SVC, 8'hAA);
    edges_to_req(40, n);
    check("R5 clear restarts count", n, 16);
  endtask

  task automatic t_double_clear();
    int n;
    restart(1'b1, 2'd0);
    wr(SVC, 8'h55);
    wr(SVC, 8'hAA);
    wr(SVC, 8'hAA);
    edges_to_req(40, n);
    check("R5 second clear ignored", n, 15);
  endtask

  task automatic t_clear_unarmed();
    int n;
    restart(1'b1, 2'd0);
    wr(SVC, 8'hAA);
    edges_to_req(40, n);
    check("R6 unarmed clear ignored", n, 15);
  endtask

  task automatic t_interleave();
    int n;
    restart(1'b1, 2'd0);
    wr(SVC, 8'h55);
    wr(SVC, 8'h3C);
    wr(16'h103B, 8'hAA);
    wr(SVC, 8'hAA);
    edges_to_req(40, n);
    check("R7 other writes keep armed", n, 16);
  endtask

  task automatic t_enable();
    int n;
    int seen = 0;
    restart(1'b0, 2'd0);
    for (int i = 0; i < 100; i++) begin
      tick();
      if (rst_req) seen++;
    end
    check("R8 no request while disabled", seen, 0);
    enable = 1'b1;
    edges_to_req(40, n);
    check("R8 count from zero on enable", n, 16);
    wait_drop();
    for (int i = 0; i < 10; i++) tick();
    enable = 1'b0;
    tick();
    enable = 1'b1;
    edges_to_req(40, n);
    check("R8 disable clears count", n, 16);
  endtask

  task automatic t_race();
    int n;
    restart(1'b1, 2'd0);
    wr(SVC, 8'h55);
    for (int i = 0; i < 14; i++) tick();
    wr(SVC, 8'hAA);
    check("R9 clear wins at terminal edge", rst_req, 0);
    edges_to_req(40, n);
    check("R9 next request after clear", n, 16);
  endtask

  initial begin
    t_reset_state();
    t_timeouts();
    t_pulse();
    t_disarm_after_pulse();
    t_arm_only();
    t_service();
    t_double_clear();
    t_clear_unarmed();
    t_interleave();
    t_enable();
    t_race();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule